// File: doc/BRIEF.md
# ALU with Condition Code Flags

This block is the arithmetic and logic stage of a small register-to-register datapath. Each operation takes two 32-bit operands. The second operand comes either from a register value or from an immediate constant. The operation set covers add, subtract, the bitwise functions, logical and arithmetic shifts, rotates and a compare. The result is captured in an output register together with a write strobe. The strobe tells the register file whether to store the result.

Two condition flags sit next to the result: a sign flag and a zero flag. Every defined operation that is issued loads them, and they hold their value between operations. Compare subtracts the second operand from the first, updates only the flags and leaves the result untouched. A separate 3-bit relation select asks whether less, greater, greater-or-equal, less-or-equal, equal or not-equal holds under the stored flags. The answer is decoded directly from those two flag bits, so a branch unit can test it in the cycle after the compare.

Top module: `alu_cc_core`

## Requirements
- R1: Operation code 0 gives A+B and code 1 gives A−B, both modulo 2^32.
- R2: Code 2 gives A AND B, code 3 gives A OR B, code 4 gives A XOR B, and code 5 gives the bitwise inverse of A, with B ignored.
- R3: Code 6 shifts A left and code 7 shifts A right, both filling with zeros. The amount is B[4:0], so only the low five bits of B count, and an amount of 0 returns A unchanged.
- R4: Code 9 shifts A right and fills the vacated high bits with the original A[31]. Code 8 gives exactly the same value as code 6.
- R5: Code 10 rotates A left and code 11 rotates A right by B[4:0] places. Bits leaving one end re-enter at the other end.
- R6: When use_imm is 1, the imm input replaces opb as operand B for every operation.
- R7: On a clock edge with op_en high and a defined code (0–12), flag_s takes bit 31 of the operation value and flag_z becomes 1 exactly when that value is zero. With op_en low, both flags hold.
- R8: Code 12 (compare) loads the flags from A−B. The following cycle res_we is 0 and res keeps its previous value.
- R9: For codes 0–11 issued with op_en high, res and res_we=1 appear after the next rising edge. In any cycle without such an issue, res_we is 0 and res holds.
- R10: cond_true is combinational from the stored flags and cond_sel: 0 less = S, 1 greater = !S&&!Z, 2 greater-or-equal = !S, 3 less-or-equal = S||Z, 4 equal = Z, 5 not-equal = !Z. Codes 6 and 7 give 0.
- R11: A synchronous active-high reset clears res, res_we, flag_s and flag_z.
- R12: Codes 13–15 issued with op_en high write no result and leave both flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_en | input | 1 | Issue strobe; also the flag-write enable |
| op_sel | input | 4 | Operation code |
| opa | input | 32 | Operand A |
| opb | input | 32 | Register value for operand B |
| imm | input | 32 | Immediate value for operand B |
| use_imm | input | 1 | Selects imm as operand B |
| cond_sel | input | 3 | Relation select |
| res | output | 32 | Registered result |
| res_we | output | 1 | Result write strobe |
| flag_s | output | 1 | Stored sign flag |
| flag_z | output | 1 | Stored zero flag |
| cond_true | output | 1 | Selected relation holds under stored flags |

## Verification
The result, write strobe and both flags are due one rising edge after an issue. The driver therefore tags each expected item with the cycle after the one in which it drives, and the monitor pops and compares the item at the falling edge of that cycle. The relation output has no register of its own. After each compare, the bench waits until the flags have been loaded. It then walks all eight relation codes inside the low half of the next cycle and samples each shortly after changing the select. Idle cycles push hold items, so flag and result retention is checked every cycle as well.

// File: rtl/alu_cc_pkg.sv
`timescale 1ns/1ps
package alu_cc_pkg;
  localparam int OPW  = 4;
  localparam int RELW = 3;

  typedef enum logic [OPW-1:0] {
    OP_ADD = 4'd0,  OP_SUB = 4'd1,  OP_AND = 4'd2,  OP_OR  = 4'd3,
    OP_XOR = 4'd4,  OP_NOT = 4'd5,  OP_SHL = 4'd6,  OP_SHR = 4'd7,
    OP_SAL = 4'd8,  OP_SAR = 4'd9,  OP_ROL = 4'd10, OP_ROR = 4'd11,
    OP_CMP = 4'd12
  } alu_op_e;

  typedef enum logic [RELW-1:0] {
    REL_LT = 3'd0, REL_GT = 3'd1, REL_GE = 3'd2,
    REL_LE = 3'd3, REL_EQ = 3'd4, REL_NE = 3'd5
  } rel_e;
endpackage

// File: rtl/alu_cc_shift.sv
`timescale 1ns/1ps
module alu_cc_shift #(
  parameter int W = 32,
  localparam int SHW = $clog2(W)
) (
  input  logic [W-1:0]   din,
  input  logic [SHW-1:0] amt,
  output logic [W-1:0]   shl_o,
  output logic [W-1:0]   shr_o,
  output logic [W-1:0]   sar_o,
  output logic [W-1:0]   rol_o,
  output logic [W-1:0]   ror_o
);
  // zero-filled shifts
  assign shl_o = din << amt;
  assign shr_o = din >> amt;

  // sign fill: logical shift plus a mask of the vacated high bits
  logic [W-1:0] hi_mask;
  assign hi_mask = ~({W{1'b1}} >> amt);
  assign sar_o   = (din >> amt) | (din[W-1] ? hi_mask : '0);

  // rotates as log2(W) conditional stages, one per amount bit
  logic [W-1:0] rl [SHW+1];
  logic [W-1:0] rr [SHW+1];
  assign rl[0] = din;
  assign rr[0] = din;

  for (genvar k = 0; k < SHW; k++) begin : g_rot
    localparam int D = 1 << k;
    assign rl[k+1] = amt[k] ? {rl[k][W-1-D:0], rl[k][W-1:W-D]} : rl[k];
    assign rr[k+1] = amt[k] ? {rr[k][D-1:0],   rr[k][W-1:D]}   : rr[k];
  end

  assign rol_o = rl[SHW];
  assign ror_o = rr[SHW];
endmodule

// File: rtl/alu_cc_exec.sv
`timescale 1ns/1ps
module alu_cc_exec
  import alu_cc_pkg::*;
#(
  parameter int W = 32,
  localparam int SHW = $clog2(W)
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  alu_op_e      op,
  output logic [W-1:0] val,
  output logic         wr,
  output logic         upd
);
  // shared adder for add, subtract and compare
  logic         is_sub;
  logic [W-1:0] b_in;
  logic [W-1:0] addsum;
  assign is_sub = (op == OP_SUB) || (op == OP_CMP);
  assign b_in   = is_sub ? ~opb : opb;
  assign addsum = opa + b_in + {{(W-1){1'b0}}, is_sub};

  logic [W-1:0] shl_v, shr_v, sar_v, rol_v, ror_v;

  alu_cc_shift #(.W(W)) u_shift (
    .din   (opa),
    .amt   (opb[SHW-1:0]),
    .shl_o (shl_v),
    .shr_o (shr_v),
    .sar_o (sar_v),
    .rol_o (rol_v),
    .ror_o (ror_v)
  );

  always_comb begin
    val = '0;
    wr  = 1'b1;
    upd = 1'b1;
    unique case (op)
      OP_ADD, OP_SUB: val = addsum;
      OP_AND:         val = opa & opb;
      OP_OR:          val = opa | opb;
      OP_XOR:         val = opa ^ opb;
      OP_NOT:         val = ~opa;
      OP_SHL, OP_SAL: val = shl_v;
      OP_SHR:         val = shr_v;
      OP_SAR:         val = sar_v;
      OP_ROL:         val = rol_v;
      OP_ROR:         val = ror_v;
      OP_CMP: begin
        val = addsum;
        wr  = 1'b0;
      end
      default: begin
        wr  = 1'b0;
        upd = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/alu_cc_flags.sv
`timescale 1ns/1ps
module alu_cc_flags #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         upd,
  input  logic [W-1:0] val,
  output logic         s_q,
  output logic         z_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      s_q <= 1'b0;
      z_q <= 1'b0;
    end else if (upd) begin
      s_q <= val[W-1];
      z_q <= (val == '0);
    end
  end
endmodule

// File: rtl/alu_cc_cond.sv
`timescale 1ns/1ps
module alu_cc_cond
  import alu_cc_pkg::*;
(
  input  logic            s,
  input  logic            z,
  input  logic [RELW-1:0] sel,
  output logic            hit
);
  localparam int NREL = 1 << RELW;
  logic [NREL-1:0] rel_vec;

  always_comb begin
    rel_vec         = '0;
    rel_vec[REL_LT] = s;
    rel_vec[REL_GT] = !s && !z;
    rel_vec[REL_GE] = !s;
    rel_vec[REL_LE] = s || z;
    rel_vec[REL_EQ] = z;
    rel_vec[REL_NE] = !z;
  end

  assign hit = rel_vec[sel];
endmodule

// File: rtl/alu_cc_core.sv
`timescale 1ns/1ps
module alu_cc_core
  import alu_cc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            op_en,
  input  logic [OPW-1:0]  op_sel,
  input  logic [W-1:0]    opa,
  input  logic [W-1:0]    opb,
  input  logic [W-1:0]    imm,
  input  logic            use_imm,
  input  logic [RELW-1:0] cond_sel,
  output logic [W-1:0]    res,
  output logic            res_we,
  output logic            flag_s,
  output logic            flag_z,
  output logic            cond_true
);
  logic [W-1:0] b_sel;
  logic [W-1:0] ex_val;
  logic         ex_wr;
  logic         ex_upd;

  assign b_sel = use_imm ? imm : opb;

  alu_cc_exec #(.W(W)) u_exec (
    .opa (opa),
    .opb (b_sel),
    .op  (alu_op_e'(op_sel)),
    .val (ex_val),
    .wr  (ex_wr),
    .upd (ex_upd)
  );

  alu_cc_flags #(.W(W)) u_flags (
    .clk (clk),
    .rst (rst),
    .upd (op_en && ex_upd),
    .val (ex_val),
    .s_q (flag_s),
    .z_q (flag_z)
  );

  alu_cc_cond u_cond (
    .s   (flag_s),
    .z   (flag_z),
    .sel (cond_sel),
    .hit (cond_true)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res    <= '0;
      res_we <= 1'b0;
    end else begin
      res_we <= op_en && ex_wr;
      if (op_en && ex_wr) res <= ex_val;
    end
  end
endmodule

// File: rtl/alu_cc_chk.sv
`timescale 1ns/1ps
module alu_cc_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         op_en,
  input logic [3:0]   op_sel,
  input logic [2:0]   cond_sel,
  input logic [W-1:0] res,
  input logic         res_we,
  input logic         flag_s,
  input logic         flag_z,
  input logic         cond_true
);
  p_cmp_nowrite_r8: assert property (@(posedge clk) disable iff (rst)
    (op_en && op_sel == 4'd12) |=> !res_we);

  p_flags_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !op_en |=> ($stable(flag_s) && $stable(flag_z)));

  p_zero_tracks_r7: assert property (@(posedge clk) disable iff (rst)
    res_we |-> (flag_z == (res == '0)));

  p_sign_tracks_r7: assert property (@(posedge clk) disable iff (rst)
    res_we |-> (flag_s == res[W-1]));

  p_res_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !(op_en && op_sel < 4'd12) |=> (!res_we && $stable(res)));

  p_undef_op_r12: assert property (@(posedge clk) disable iff (rst)
    (op_en && op_sel > 4'd12) |=> ($stable(flag_s) && $stable(flag_z)));

  p_reset_clear_r11: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!res_we && !flag_s && !flag_z && res == '0));

  p_unused_rel_r10: assert property (@(posedge clk) disable iff (rst)
    (cond_sel > 3'd5) |-> !cond_true);
endmodule

bind alu_cc_core alu_cc_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .op_en     (op_en),
  .op_sel    (op_sel),
  .cond_sel  (cond_sel),
  .res       (res),
  .res_we    (res_we),
  .flag_s    (flag_s),
  .flag_z    (flag_z),
  .cond_true (cond_true)
);

// File: tb/sim_alu_cc_core.sv
`timescale 1ns/1ps
module sim_alu_cc_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_en = 1'b0;
  logic [3:0]  op_sel = '0;
  logic [31:0] opa = '0, opb = '0, imm = '0;
  logic        use_imm = 1'b0;
  logic [2:0]  cond_sel = '0;
  logic [31:0] res;
  logic        res_we, flag_s, flag_z, cond_true;

  always #2.5 clk = ~clk;

  alu_cc_core #(.W(32)) u0 (
    .clk(clk), .rst(rst), .op_en(op_en), .op_sel(op_sel), .opa(opa),
    .opb(opb), .imm(imm), .use_imm(use_imm), .cond_sel(cond_sel),
    .res(res), .res_we(res_we), .flag_s(flag_s), .flag_z(flag_z),
    .cond_true(cond_true)
  );

  typedef struct {
    logic        we;
    logic [31:0] val;
    logic        s;
    logic        z;
    int          due;
    string       req;
  } exp_t;

  exp_t sbq[$];
  int   cyc = 0;
  int   n_chk = 0;
  int   n_fail = 0;
  logic [31:0] m_res = '0;
  logic        m_s = 1'b0, m_z = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic [3:0] op,
                                        input logic [31:0] a, input logic [31:0] b);
    int n;
    n = int'(b[4:0]);
    case (op)
      4'd0:       return a + b;
      4'd1:       return a - b;
      4'd2:       return a & b;
      4'd3:       return a | b;
      4'd4:       return a ^ b;
      4'd5:       return ~a;
      4'd6, 4'd8: return a << n;
      4'd7:       return a >> n;
      4'd9:       return $signed(a) >>> n;
      4'd10:      return (n == 0) ? a : ((a << n) | (a >> (32 - n)));
      4'd11:      return (n == 0) ? a : ((a >> n) | (a << (32 - n)));
      4'd12:      return a - b;
      default:    return 32'h0;
    endcase
  endfunction

  function automatic logic rel(input logic s, input logic z, input int code);
    case (code)
      0: return s;
      1: return !s && !z;
      2: return !s;
      3: return s || z;
      4: return z;
      5: return !z;
      default: return 1'b0;
    endcase
  endfunction

  // monitor: pops expected items in the cycle they are due
  always @(negedge clk) begin
    exp_t e;
    while (sbq.size() > 0 && sbq[0].due <= cyc) begin
      e = sbq.pop_front();
      chk(e.req, "res_we", {31'b0, res_we}, {31'b0, e.we});
      chk(e.req, "res",    res, e.val);
      chk(e.req, "flag_s", {31'b0, flag_s}, {31'b0, e.s});
      chk(e.req, "flag_z", {31'b0, flag_z}, {31'b0, e.z});
    end
  end

  task automatic push(input logic we, input string req);
    exp_t e;
    e.we = we; e.val = m_res; e.s = m_s; e.z = m_z;
    e.due = cyc + 1; e.req = req;
    sbq.push_back(e);
  endtask

  task automatic do_op(input logic [3:0] op, input logic [31:0] a,
                       input logic [31:0] b, input logic ui,
                       input logic [31:0] im, input string req);
    logic [31:0] bs, v;
    @(negedge clk);
    op_en = 1'b1; op_sel = op; opa = a; opb = b; use_imm = ui; imm = im;
    bs = ui ? im : b;
    v  = model(op, a, bs);
    if (op <= 4'd11) m_res = v;
    if (op <= 4'd12) begin
      m_s = v[31];
      m_z = (v == 32'h0);
    end
    push(op <= 4'd11, req);
  endtask

  task automatic idle(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      op_en = 1'b0; opa = $urandom; opb = $urandom;
      push(1'b0, req);
    end
  endtask

  // all relation codes against the flags loaded by the previous op
  task automatic sweep(input string req);
    @(negedge clk);
    op_en = 1'b0;
    push(1'b0, req);
    for (int c = 0; c < 8; c++) begin
      cond_sel = 3'(c);
      #0.1;
      chk(req, $sformatf("cond_true sel=%0d", c), {31'b0, cond_true},
          {31'b0, rel(m_s, m_z, c)});
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    chk("R11", "res", res, 32'h0);
    chk("R11", "res_we", {31'b0, res_we}, 32'h0);
    chk("R11", "flags", {30'b0, flag_s, flag_z}, 32'h0);
    rst = 1'b0;

    do_op(4'd0, 32'd7, 32'd5, 1'b0, 32'h0, "R1");
    do_op(4'd0, 32'hFFFF_FFFF, 32'd1, 1'b0, 32'h0, "R1");
    do_op(4'd1, 32'd3, 32'd5, 1'b0, 32'h0, "R1");
    do_op(4'd2, 32'hA295_850F, 32'h5BEA_28BA, 1'b0, 32'h0, "R2");
    do_op(4'd3, 32'hA295_850F, 32'h5BEA_28BA, 1'b0, 32'h0, "R2");
    do_op(4'd4, 32'hF0F0_1234, 32'hF0F0_1234, 1'b0, 32'h0, "R2");
    do_op(4'd5, 32'h0, 32'h1234_5678, 1'b0, 32'h0, "R2");
    do_op(4'd6, 32'h8000_0003, 32'd1, 1'b0, 32'h0, "R3");
    do_op(4'd6, 32'hDEAD_BEEF, 32'd0, 1'b0, 32'h0, "R3");
    do_op(4'd6, 32'h0000_0001, 32'd31, 1'b0, 32'h0, "R3");
    do_op(4'd6, 32'h0000_0005, 32'd33, 1'b0, 32'h0, "R3");
    do_op(4'd7, 32'h8000_0000, 32'd31, 1'b0, 32'h0, "R3");
    do_op(4'd9, 32'h8000_0010, 32'd4, 1'b0, 32'h0, "R4");
    do_op(4'd9, 32'h4000_0010, 32'd4, 1'b0, 32'h0, "R4");
    do_op(4'd8, 32'h0000_0009, 32'd1, 1'b0, 32'h0, "R4");
    do_op(4'd10, 32'h8000_0001, 32'd1, 1'b0, 32'h0, "R5");
    do_op(4'd11, 32'h8000_0001, 32'd1, 1'b0, 32'h0, "R5");
    do_op(4'd10, 32'h1234_5678, 32'd12, 1'b0, 32'h0, "R5");
    do_op(4'd11, 32'hCAFE_F00D, 32'd0, 1'b0, 32'h0, "R5");
    do_op(4'd0, 32'd100, 32'hFFFF_0000, 1'b1, 32'd23, "R6");
    do_op(4'd6, 32'h1, 32'd0, 1'b1, 32'd4, "R6");
    idle(3, "R7");
    do_op(4'd1, 32'd9, 32'd9, 1'b0, 32'h0, "R7");
    idle(2, "R9");

    // compares: equal, less, greater
    do_op(4'd12, 32'd5, 32'd5, 1'b0, 32'h0, "R8");
    sweep("R10");
    do_op(4'd12, 32'd3, 32'd9, 1'b0, 32'h0, "R8");
    sweep("R10");
    do_op(4'd12, 32'd9, 32'd3, 1'b1, 32'd3, "R8");
    sweep("R10");

    // undefined codes leave everything alone
    do_op(4'd13, 32'h0, 32'h0, 1'b0, 32'h0, "R12");
    do_op(4'd15, 32'h8000_0000, 32'h1, 1'b0, 32'h0, "R12");
    sweep("R12");

    // reset in the middle of operation
    do_op(4'd1, 32'd0, 32'd1, 1'b0, 32'h0, "R11");
    @(negedge clk);
    op_en = 1'b0; rst = 1'b1;
    @(negedge clk);
    chk("R11", "res after reset", res, 32'h0);
    chk("R11", "flags after reset", {30'b0, flag_s, flag_z}, 32'h0);
    rst = 1'b0;
    m_res = '0; m_s = 1'b0; m_z = 1'b0;
    sweep("R10");

    idle(3, "R9");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule